// File: doc/BRIEF.md
# SPI Master Word Serialiser

This block moves one parallel word at a time across a single-channel SPI link in master mode. A word of 1 to 32 bits is taken from a valid/ready pair, and the block drives the serial clock, one frame select line and the outgoing data line. It samples the incoming data line and returns the received word with a one-cycle completion strobe. Word queues, register access and interrupts are left to the surrounding logic.

The link timing is not chosen by a two-bit mode number. Four separate control bits set it: the edge that captures incoming data, the resting level of the serial clock, an extra lead-in before the first clock edge, and the clock edge the frame is taken to start on. The lead-in is one serial-clock period or half a period, and the frame-start bit decides which. With a suitable choice of these bits the four usual SPI modes can be produced. A clock divide ratio sets the serial clock rate. A bit-order field selects whether the LSB or the MSB goes first. A word that follows straight on from the previous one keeps the frame asserted.

Top module: `spi_word_engine`

## Requirements
- R1: Each serial-clock half period lasts div_ratio/2 system-clock cycles, with odd ratios rounded down. A ratio below 4 behaves as 4, giving a half period of 2 cycles.
- R2: While no word is in progress, sclk rests at clk_idle_hi. The first edge of each word moves it away from that level.
- R3: When cap_fall is 0, miso is sampled on rising sclk edges. When cap_fall is 1 it is sampled on falling edges. mosi changes only on edges of the other direction, and the first bit of a word is on mosi from the cycle the frame asserts.
- R4: The first sclk edge of a word comes H cycles after the word starts when lead_dly is 0, where H is the half period. With lead_dly 1 it comes 2H cycles after the start when start_fall is 1, and 3H cycles after when start_fall is 0.
- R5: word_len values 1 to 32 give that many bits, and 0 or any value above 32 gives 32 bits. A word of N bits makes exactly 2N sclk edges.
- R6: bit_order value 1 shifts LSB first. Values 0, 2 and 3 shift MSB first. The same order applies to sending and receiving.
- R7: Words are right-justified in tx_data and rx_data, and rx_data bits at and above N read zero. rx_data updates in the cycle done rises and holds until the next completed word.
- R8: frame_sel is at level frame_act_hi while a word is in progress and at the opposite level otherwise.
- R9: done is a one-cycle pulse that rises H cycles after the final sclk edge of a word.
- R10: tx_ready is high while idle and in the last cycle of a word. A word offered then starts at once with the frame kept asserted, so a burst of words gives one frame deassertion.
- R11: en low drops the current word without a done pulse, returns sclk to its idle level and frame_sel to inactive, and holds tx_ready low.
- R12: After reset, frame_sel is inactive, sclk is at its idle level, and mosi, done and rx_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Engine enable; low aborts and idles |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 32 | Transmit word, right-justified |
| tx_ready | output | 1 | Engine takes the offered word this cycle |
| word_len | input | 6 | Bits per word, 1 to 32 |
| bit_order | input | 2 | 1 = LSB first, other values MSB first |
| div_ratio | input | 8 | System clocks per serial clock period |
| cap_fall | input | 1 | 0 = capture on rising edge, 1 = on falling edge |
| clk_idle_hi | input | 1 | Resting level of sclk |
| lead_dly | input | 1 | Adds a lead-in before the first edge |
| start_fall | input | 1 | Frame-start edge; sets lead-in length |
| frame_act_hi | input | 1 | Active level of frame_sel |
| sclk | output | 1 | Serial clock |
| frame_sel | output | 1 | Frame / chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_data | output | 32 | Received word, right-justified |
| done | output | 1 | Word complete pulse |

## Verification
The hardest case to reach is a word offered in the last cycle of the previous one. The frame must stay up across that boundary while the lead-in, the edge count and the shift pointers all restart. The stimulus keeps tx_valid high with the next word as soon as the previous word is taken, so every burst of two or three words crosses that boundary under random timing bits and lengths. A bench-side receiver rebuilds each word from mosi at the capture edges. With miso looped back from mosi, the same word also returns on rx_data, so send order and receive order are checked separately.

// File: rtl/spi_word_engine_pkg.sv
package spi_word_engine_pkg;

    typedef enum logic [1:0] {
        SWE_IDLE  = 2'd0,
        SWE_LEAD  = 2'd1,
        SWE_RUN   = 2'd2,
        SWE_TRAIL = 2'd3
    } swe_state_e;

    typedef struct packed {
        logic cap_fall;
        logic idle_hi;
        logic lead_dly;
        logic start_fall;
    } swe_timing_t;

    localparam logic [1:0] SWE_ORDER_LSB = 2'd1;

    // half period in system clocks from the divide ratio
    function automatic int unsigned swe_half(input int unsigned ratio);
        return (ratio < 4) ? 2 : (ratio >> 1);
    endfunction

    // cycles between word start and the first serial clock edge
    function automatic int unsigned swe_lead(input int unsigned half,
                                             input logic dly,
                                             input logic start_fall);
        if (!dly)
            return half;
        return start_fall ? 2 * half : 3 * half;
    endfunction

    // effective bit count of a word
    function automatic int unsigned swe_len(input int unsigned raw,
                                            input int unsigned maxw);
        return (raw == 0 || raw > maxw) ? maxw : raw;
    endfunction

    // an edge to new_level samples input when its direction matches the capture bit
    function automatic logic swe_is_capture(input logic new_level,
                                            input logic cap_fall);
        return new_level ^ cap_fall;
    endfunction

endpackage

// File: rtl/swe_sequencer.sv
module swe_sequencer
    import spi_word_engine_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6,
    parameter int DIV_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               tx_valid,
    input  logic [LEN_W-1:0]   word_len,
    input  logic [DIV_W-1:0]   div_ratio,
    input  swe_timing_t        timing,
    output logic               tx_ready,
    output logic               accept,
    output logic               frame_on,
    output logic               sclk_q,
    output logic               edge_go,
    output logic               edge_first,
    output logic               edge_capture,
    output logic               word_end,
    output logic               done_q
);

    localparam int CNT_W  = DIV_W + 1;
    localparam int EDGE_W = $clog2(2 * DATA_W) + 1;

    swe_state_e        state;
    logic [CNT_W-1:0]  timer;
    logic [CNT_W-1:0]  half_q;
    logic [EDGE_W-1:0] edges;
    logic [EDGE_W-1:0] nedge_q;
    logic              cap_fall_q;

    logic [CNT_W-1:0]  half_new;
    logic [CNT_W-1:0]  lead_new;
    logic [EDGE_W-1:0] nedge_new;
    logic              tick;

    always_comb begin
        half_new  = CNT_W'(swe_half(int'(div_ratio)));
        lead_new  = CNT_W'(swe_lead(swe_half(int'(div_ratio)),
                                    timing.lead_dly, timing.start_fall));
        nedge_new = EDGE_W'(2 * swe_len(int'(word_len), DATA_W));
    end

    assign tick         = (timer == '0);
    assign word_end     = en && (state == SWE_TRAIL) && tick;
    assign tx_ready     = en && ((state == SWE_IDLE) || ((state == SWE_TRAIL) && tick));
    assign accept       = tx_ready && tx_valid;
    assign edge_go      = en && tick && ((state == SWE_LEAD) || (state == SWE_RUN));
    assign edge_first   = (edges == '0);
    assign edge_capture = swe_is_capture(~sclk_q, cap_fall_q);
    assign frame_on     = (state != SWE_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SWE_IDLE;
            timer      <= '0;
            half_q     <= CNT_W'(2);
            edges      <= '0;
            nedge_q    <= '0;
            cap_fall_q <= 1'b0;
            sclk_q     <= timing.idle_hi;
            done_q     <= 1'b0;
        end else if (!en) begin
            state  <= SWE_IDLE;
            timer  <= '0;
            edges  <= '0;
            sclk_q <= timing.idle_hi;
            done_q <= 1'b0;
        end else begin
            done_q <= word_end;
            if (accept) begin
                state      <= SWE_LEAD;
                timer      <= lead_new - CNT_W'(1);
                half_q     <= half_new;
                nedge_q    <= nedge_new;
                cap_fall_q <= timing.cap_fall;
                edges      <= '0;
                sclk_q     <= timing.idle_hi;
            end else begin
                unique case (state)
                    SWE_IDLE: begin
                        sclk_q <= timing.idle_hi;
                    end
                    SWE_LEAD, SWE_RUN: begin
                        if (tick) begin
                            sclk_q <= ~sclk_q;
                            edges  <= edges + EDGE_W'(1);
                            timer  <= half_q - CNT_W'(1);
                            state  <= (edges + EDGE_W'(1) == nedge_q) ? SWE_TRAIL : SWE_RUN;
                        end else begin
                            timer <= timer - CNT_W'(1);
                        end
                    end
                    SWE_TRAIL: begin
                        if (tick)
                            state <= SWE_IDLE;
                        else
                            timer <= timer - CNT_W'(1);
                    end
                    default: state <= SWE_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/swe_datapath.sv
module swe_datapath
    import spi_word_engine_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               accept,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic [LEN_W-1:0]   word_len,
    input  logic [1:0]         bit_order,
    input  logic               edge_go,
    input  logic               edge_first,
    input  logic               edge_capture,
    input  logic               word_end,
    input  logic               miso,
    output logic               mosi_q,
    output logic [DATA_W-1:0]  rx_data_q
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_acc;
    logic [IDX_W-1:0]  nlast_q;
    logic              lsb_q;
    logic [IDX_W-1:0]  tx_idx;
    logic [IDX_W-1:0]  rx_idx;

    logic [IDX_W-1:0]  nlast_new;
    logic              lsb_new;
    logic [IDX_W-1:0]  tx_next;

    function automatic logic [IDX_W-1:0] bit_pos(input logic lsb,
                                                 input logic [IDX_W-1:0] last,
                                                 input logic [IDX_W-1:0] idx);
        return lsb ? idx : last - idx;
    endfunction

    always_comb begin
        nlast_new = IDX_W'(swe_len(int'(word_len), DATA_W) - 1);
        lsb_new   = (bit_order == SWE_ORDER_LSB);
        tx_next   = tx_idx + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q      <= '0;
            rx_acc    <= '0;
            nlast_q   <= '0;
            lsb_q     <= 1'b0;
            tx_idx    <= '0;
            rx_idx    <= '0;
            mosi_q    <= 1'b0;
            rx_data_q <= '0;
        end else if (!en) begin
            tx_idx <= '0;
            rx_idx <= '0;
            mosi_q <= 1'b0;
        end else begin
            if (word_end)
                rx_data_q <= rx_acc;
            if (accept) begin
                tx_q    <= tx_data;
                nlast_q <= nlast_new;
                lsb_q   <= lsb_new;
                tx_idx  <= '0;
                rx_idx  <= '0;
                rx_acc  <= '0;
                mosi_q  <= tx_data[bit_pos(lsb_new, nlast_new, '0)];
            end else if (word_end) begin
                mosi_q <= 1'b0;
            end else if (edge_go) begin
                if (edge_capture) begin
                    rx_acc[bit_pos(lsb_q, nlast_q, rx_idx)] <= miso;
                    rx_idx <= rx_idx + IDX_W'(1);
                end else if (!edge_first && (tx_idx != nlast_q)) begin
                    tx_idx <= tx_next;
                    mosi_q <= tx_q[bit_pos(lsb_q, nlast_q, tx_next)];
                end
            end
        end
    end

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import spi_word_engine_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [1:0]        bit_order,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic              cap_fall,
    input  logic              clk_idle_hi,
    input  logic              lead_dly,
    input  logic              start_fall,
    input  logic              frame_act_hi,
    output logic              sclk,
    output logic              frame_sel,
    output logic              mosi,
    input  logic              miso,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);

    swe_timing_t timing;
    logic        accept;
    logic        frame_on;
    logic        edge_go;
    logic        edge_first;
    logic        edge_capture;
    logic        word_end;

    always_comb begin
        timing.cap_fall   = cap_fall;
        timing.idle_hi    = clk_idle_hi;
        timing.lead_dly   = lead_dly;
        timing.start_fall = start_fall;
    end

    swe_sequencer #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W),
        .DIV_W  (DIV_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .tx_valid     (tx_valid),
        .word_len     (word_len),
        .div_ratio    (div_ratio),
        .timing       (timing),
        .tx_ready     (tx_ready),
        .accept       (accept),
        .frame_on     (frame_on),
        .sclk_q       (sclk),
        .edge_go      (edge_go),
        .edge_first   (edge_first),
        .edge_capture (edge_capture),
        .word_end     (word_end),
        .done_q       (done)
    );

    swe_datapath #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_dp (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .accept       (accept),
        .tx_data      (tx_data),
        .word_len     (word_len),
        .bit_order    (bit_order),
        .edge_go      (edge_go),
        .edge_first   (edge_first),
        .edge_capture (edge_capture),
        .word_end     (word_end),
        .miso         (miso),
        .mosi_q       (mosi),
        .rx_data_q    (rx_data)
    );

    assign frame_sel = frame_on ? frame_act_hi : ~frame_act_hi;

endmodule

// File: rtl/swe_checker.sv
module swe_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic tx_valid,
    input logic tx_ready,
    input logic frame_act_hi,
    input logic clk_idle_hi,
    input logic frame_sel,
    input logic sclk,
    input logic done
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(frame_sel == frame_act_hi));

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (frame_sel != frame_act_hi) && (sclk == $past(clk_idle_hi)));

    // R10
    accept_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tx_valid && tx_ready) |=> (frame_sel == frame_act_hi));

    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        ((frame_sel != frame_act_hi) && $past(frame_sel != frame_act_hi))
        |-> (sclk == $past(clk_idle_hi)));

endmodule

bind spi_word_engine swe_checker u_chk (.*);

// File: tb/sim_spi_word_engine.sv
`timescale 1ns/1ps
module sim_spi_word_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_data = '0;
    logic [5:0]  word_len = 6'd8;
    logic [1:0]  bit_order = 2'd0;
    logic [7:0]  div_ratio = 8'd4;
    logic        cap_fall = 1'b0;
    logic        clk_idle_hi = 1'b0;
    logic        lead_dly = 1'b0;
    logic        start_fall = 1'b0;
    logic        frame_act_hi = 1'b0;
    logic        miso;
    int          miso_mode = 0;
    wire         tx_ready, sclk, frame_sel, mosi, done;
    wire [31:0]  rx_data;

    always #4 clk = ~clk;

    always_comb miso = (miso_mode == 0) ? mosi : (miso_mode == 1);

    spi_word_engine u0 (
        .clk(clk), .rst(rst), .en(en), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .word_len(word_len), .bit_order(bit_order),
        .div_ratio(div_ratio), .cap_fall(cap_fall), .clk_idle_hi(clk_idle_hi),
        .lead_dly(lead_dly), .start_fall(start_fall), .frame_act_hi(frame_act_hi),
        .sclk(sclk), .frame_sel(frame_sel), .mosi(mosi), .miso(miso),
        .rx_data(rx_data), .done(done)
    );

    // expected-value helpers
    function automatic int e_len(input int raw);
        return (raw == 0 || raw > 32) ? 32 : raw;
    endfunction
    function automatic int e_half(input int ratio);
        return (ratio < 4) ? 2 : ratio / 2;
    endfunction
    function automatic int e_lead(input int h, input logic dly, input logic sf);
        return !dly ? h : (sf ? 2 * h : 3 * h);
    endfunction
    function automatic logic [31:0] e_mask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    endfunction

    // main-process counters
    int n_checks = 0;
    int n_errors = 0;
    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor-process counters
    int m_checks = 0;
    int m_errors = 0;
    task automatic mcheck(input bit ok, input string tag,
                          input logic [31:0] act, input logic [31:0] exp);
        m_checks++;
        if (!ok) begin
            m_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] q_tx [0:255];
    logic [7:0]  q_wr = '0;
    logic [7:0]  q_rd = '0;

    // bench-side receiver and timing monitor
    logic        prev_sclk, prev_act, act;
    int          m_cyc, m_since, m_edges, m_lead, m_capk, frame_falls, done_cnt;
    bit          m_int_bad;
    logic [31:0] m_cap, t, mk;
    int          n, h;

    initial begin
        frame_falls = 0; done_cnt = 0; prev_act = 0; prev_sclk = 0;
        m_cyc = 0; m_since = 0; m_edges = 0; m_lead = 0; m_capk = 0;
        m_int_bad = 0; m_cap = '0;
    end

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = sclk;
            prev_act  = 1'b0;
        end else begin
            act = (frame_sel == frame_act_hi);
            h = e_half(int'(div_ratio));
            m_cyc++;
            m_since++;
            if (act && sclk != prev_sclk) begin
                m_edges++;
                if (m_edges == 1) m_lead = m_cyc;
                else if (m_since != h) m_int_bad = 1;
                m_since = 0;
                if (sclk != cap_fall) begin
                    if (m_capk < 32) begin
                        if (bit_order == 2'd1) m_cap[m_capk] = mosi;
                        else m_cap = {m_cap[30:0], mosi};
                    end
                    m_capk++;
                end
            end
            if (done) begin
                done_cnt++;
                if (q_rd == q_wr) begin
                    mcheck(0, "R9 done with no word outstanding", 32'd1, 32'd0);
                end else begin
                    t  = q_tx[q_rd];
                    n  = e_len(int'(word_len));
                    mk = e_mask(n);
                    mcheck(rx_data == ((miso_mode == 0) ? (t & mk) : ((miso_mode == 1) ? mk : 32'h0)),
                           "R7 rx_data", rx_data,
                           (miso_mode == 0) ? (t & mk) : ((miso_mode == 1) ? mk : 32'h0));
                    mcheck(m_cap == (t & mk), "R3/R6 mosi word at capture edges", m_cap, t & mk);
                    mcheck(m_edges == 2 * n, "R5 sclk edge count", m_edges, 2 * n);
                    mcheck(m_lead == e_lead(h, lead_dly, start_fall), "R4 lead-in cycles",
                           m_lead, e_lead(h, lead_dly, start_fall));
                    mcheck(!m_int_bad, "R1 half-period spacing", {31'd0, m_int_bad}, 32'd0);
                    mcheck(m_since == h, "R9 done delay after last edge", m_since, h);
                    q_rd = q_rd + 8'd1;
                end
                m_cyc = 0; m_since = 0; m_edges = 0; m_lead = 0;
                m_int_bad = 0; m_cap = '0; m_capk = 0;
            end
            if (prev_act && !act) begin
                frame_falls++;
                if (!done) q_rd = q_wr;
            end
            if (act && !prev_act) begin
                m_cyc = 0; m_since = 0; m_edges = 0; m_lead = 0;
                m_int_bad = 0; m_cap = '0; m_capk = 0;
            end
            prev_act  = act;
            prev_sclk = sclk;
        end
    end

    // watchdog
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            $display("Result: errors=%0d of %0d checks",
                     n_errors + m_errors + 1, n_checks + m_checks + 1);
            $finish;
        end
    end

    task automatic burst(input int ratio, input int len, input logic cf, input logic ih,
                         input logic dl, input logic sf, input int ord, input logic pol,
                         input int nw, input int mm);
        int falls0;
        div_ratio = 8'(ratio); word_len = 6'(len); cap_fall = cf; clk_idle_hi = ih;
        lead_dly = dl; start_fall = sf; bit_order = 2'(ord); frame_act_hi = pol;
        miso_mode = mm;
        repeat (2) @(negedge clk);
        falls0 = frame_falls;
        for (int w = 0; w < nw; w++) begin
            tx_data = $urandom;
            q_tx[q_wr] = tx_data;
            q_wr = q_wr + 8'd1;
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            if (w == 0)
                check(frame_sel == pol, "R8 frame active level", {31'd0, frame_sel}, {31'd0, pol});
        end
        tx_valid = 1'b0;
        while (q_rd != q_wr) @(negedge clk);
        repeat (2) @(negedge clk);
        check(frame_falls - falls0 == 1, "R10 one frame deassertion per burst",
              frame_falls - falls0, 1);
        check(sclk == ih && frame_sel == !pol, "R2 idle sclk level after burst",
              {30'd0, sclk, frame_sel}, {30'd0, ih, !pol});
    endtask

    initial begin
        int seed_d;
        seed_d = $urandom(32'd4242);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        en  = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(frame_sel == 1'b1, "R12 frame inactive", {31'd0, frame_sel}, 32'd1);
        check(sclk == 1'b0, "R12 sclk idle", {31'd0, sclk}, 32'd0);
        check(mosi == 1'b0 && done == 1'b0, "R12 mosi/done low", {30'd0, mosi, done}, 32'd0);
        check(rx_data == 32'd0, "R12 rx_data zero", rx_data, 32'd0);
        check(tx_ready == 1'b1, "R10 ready when idle", {31'd0, tx_ready}, 32'd1);

        // directed: SPI modes 0..3 style settings
        burst(4, 8, 1, 0, 1, 0, 0, 0, 1, 0);
        burst(6, 8, 0, 0, 0, 1, 0, 0, 1, 0);
        burst(8, 8, 0, 1, 1, 1, 0, 1, 1, 0);
        burst(4, 8, 1, 1, 0, 0, 1, 0, 1, 0);
        // R1 ratio corners
        burst(2, 5, 0, 0, 0, 0, 0, 0, 1, 0);
        burst(7, 5, 1, 0, 1, 1, 0, 0, 1, 0);
        burst(254, 3, 0, 1, 1, 0, 1, 1, 1, 0);
        // R5 length corners
        burst(4, 1, 0, 0, 0, 0, 0, 0, 2, 0);
        burst(4, 32, 1, 1, 1, 1, 1, 0, 2, 0);
        burst(4, 0, 0, 0, 1, 0, 0, 1, 1, 0);
        burst(4, 40, 1, 0, 0, 1, 1, 0, 1, 0);
        // R6 order field values 2 and 3 are MSB first
        burst(6, 12, 0, 0, 0, 0, 2, 0, 1, 0);
        burst(6, 12, 1, 1, 1, 0, 3, 1, 1, 0);
        // R7 constant miso: upper bits zero, all ones in range
        burst(4, 13, 0, 0, 0, 0, 0, 0, 2, 1);
        burst(4, 13, 1, 1, 0, 1, 1, 0, 1, 2);
        // R10 back-to-back bursts
        burst(4, 4, 0, 0, 0, 0, 0, 0, 3, 0);

        // R11 abort mid-word
        begin
            int dc;
            div_ratio = 8'd10; word_len = 6'd16; clk_idle_hi = 1'b1;
            frame_act_hi = 1'b0; miso_mode = 0;
            repeat (2) @(negedge clk);
            tx_data = 32'hA5A5_1234;
            q_tx[q_wr] = tx_data;
            q_wr = q_wr + 8'd1;
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
            repeat (20) @(negedge clk);
            en = 1'b0;
            dc = done_cnt;
            @(negedge clk);
            check(frame_sel == 1'b1, "R11 frame inactive on abort", {31'd0, frame_sel}, 32'd1);
            check(sclk == 1'b1, "R11 sclk idle on abort", {31'd0, sclk}, 32'd1);
            check(tx_ready == 1'b0, "R11 ready low while disabled", {31'd0, tx_ready}, 32'd0);
            repeat (200) @(negedge clk);
            check(done_cnt == dc, "R11 no done after abort", done_cnt, dc);
            check(sclk == 1'b1 && frame_sel == 1'b1, "R11 outputs held idle",
                  {30'd0, sclk, frame_sel}, 32'd3);
            en = 1'b1;
            @(negedge clk);
        end
        burst(4, 16, 0, 1, 0, 0, 0, 0, 1, 0);

        // constrained random bursts
        for (int i = 0; i < 40; i++) begin
            int r, l;
            r = 4 + int'($urandom % 11);
            l = 1 + int'($urandom % 32);
            burst(r, l, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  int'($urandom % 4), 1'($urandom), 1 + int'($urandom % 3),
                  (($urandom % 5) == 0) ? 1 : 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors + m_errors, n_checks + m_checks);
        $finish;
    end

endmodule